// File: doc/BRIEF.md
# Reset Origin Discriminator

This block sits between the on-chip reset requesters (a watchdog and a clock-frequency monitor) and a shared, open-drain reset pin. Whenever a reset condition appears, it pulls the pin low for a fixed number of reference-clock cycles and then lets go. After a further fixed wait, it reads the pin level back. A pin that is still low means someone outside the device is holding reset. A pin that has returned high means the reset came from inside the device. In that case the block also records which internal source asked for it.

The pin level passes through a multi-flop synchronizer before any decision is made. The settle wait is counted on the synchronized level. An internal reset output stays high for the whole drive, settle and sample sequence and drops one cycle after the sample. A one-hot cause word keeps the outcome until the next sequence begins.

Top module: `reset_origin_ctrl`

## Requirements
- R1: While and right after the synchronous active-low reset, `pin_drive_o` and `core_rst_o` are 0 and `cause_o` is 3'b000.
- R2: While idle, a sequence starts on a `wdog_req_i` pulse, a `clkmon_req_i` pulse, or a falling edge of the synchronized pin level. `pin_drive_o` rises at the clock edge that accepts the trigger.
- R3: `pin_drive_o` stays high for exactly DRIVE_CYCLES (default 16) consecutive cycles per sequence.
- R4: The pin is sampled SETTLE_CYCLES (default 8) cycles after the released level has passed the SYNC_STAGES (default 2) flop synchronizer, which is 10 cycles after release. A low sample sets `cause_o` to 3'b001 (bit 0 = external).
- R5: A high sample with a watchdog request latched sets 3'b010 (bit 1 = watchdog). A high sample with only a clock-monitor request latched sets 3'b100 (bit 2 = clock monitor). When both are latched, the watchdog wins.
- R6: `cause_o` is at most one-hot. It clears to 3'b000 when a sequence starts and holds its value from the sample until the next sequence starts.
- R7: `core_rst_o` is high from the first drive cycle through the cycle after the sample, which is 27 cycles with the defaults.
- R8: An external low held for 32 or more cycles is classified as external, even when an internal request arrives in the same cycle as its falling edge.
- R9: Requests that arrive during a running sequence do not restart it. They are latched and take part in the classification.
- R10: A high sample with no internal request latched (a short external pulse) is classified as external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wdog_req_i | input | 1 | Watchdog reset request pulse |
| clkmon_req_i | input | 1 | Clock-monitor reset request pulse |
| pin_i | input | 1 | Level read back from the shared reset pin |
| pin_drive_o | output | 1 | High pulls the shared reset pin low |
| core_rst_o | output | 1 | Internal reset to the rest of the device |
| cause_o | output | 3 | One-hot cause: bit 0 external, bit 1 watchdog, bit 2 clock monitor |

## Verification
Two functions can land in the same cycle:
- An internal request arriving on the same clock as an external falling edge.
- Watchdog and clock-monitor requests arriving together.

The bench provokes both by changing the inputs together at one negative edge. It then judges the outcome against a behavioural model, which must show a single sequence and the correct priority: external over both, and watchdog over clock monitor. A late request that lands inside a running sequence is also compared cycle by cycle, to show it only feeds the classification.

// File: rtl/rsd_pkg.sv
// Shared types for the reset origin discriminator.
// Assumes: the one-hot cause bit positions below are decoded by software-visible status logic.
package rsd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_RELEASE = 2'd3
    } rsd_state_e;

    localparam int CAUSE_W      = 3;
    localparam int CAUSE_EXT    = 0;
    localparam int CAUSE_WDOG   = 1;
    localparam int CAUSE_CLKMON = 2;
endpackage

// File: rtl/rsd_pin_sync.sv
// Synchronizes the reset pin level and flags its falling edges.
// Assumes: STAGES >= 2; the pin idles high, so all flops reset to 1.
module rsd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              level_d_q;

    // First synchronizer flop captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= pin_i;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage shifts the level one flop down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b1;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d_q <= 1'b1;
        else        level_d_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = level_d_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rsd_seq_ctrl.sv
// Drive / settle / release sequencer with its cycle counter.
// Assumes: trigger_i is only acted upon in the idle state.
module rsd_seq_ctrl
    import rsd_pkg::*;
#(
    parameter int DRIVE_CYCLES = 16,
    parameter int WAIT_CYCLES  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trigger_i,
    output rsd_state_e state_o,
    output logic       start_o,
    output logic       sample_o
);
    localparam int MAXC = (DRIVE_CYCLES > WAIT_CYCLES) ? DRIVE_CYCLES : WAIT_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DRIVE_LAST = CW'(DRIVE_CYCLES - 1);
    localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_CYCLES - 1);

    rsd_state_e    state_q;
    logic [CW-1:0] cnt_q;

    assign start_o  = (state_q == ST_IDLE) && trigger_i;
    assign sample_o = (state_q == ST_SETTLE) && (cnt_q == WAIT_LAST);
    assign state_o  = state_q;

    // State and counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (trigger_i) state_q <= ST_DRIVE;
                end
                ST_DRIVE: begin
                    if (cnt_q == DRIVE_LAST) begin
                        state_q <= ST_SETTLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == WAIT_LAST) begin
                        state_q <= ST_RELEASE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a sequence only begins from idle with a trigger present.
    p_entry_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && cnt_q == '0) |-> $past(state_q == ST_IDLE && trigger_i))
        else $error("p_entry_from_idle_r2");

    // R7: the sample cycle is followed by exactly one release cycle.
    p_release_after_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> (state_q == ST_RELEASE) ##1 (state_q == ST_IDLE))
        else $error("p_release_after_sample_r7");
endmodule

// File: rtl/rsd_cause_reg.sv
// Latches internal requests and records the one-hot reset cause at the sample point.
// Assumes: start_i, sample_i and clear_i come from the sequencer and never coincide.
module rsd_cause_reg
    import rsd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               collect_i,
    input  logic               clear_i,
    input  logic               sample_i,
    input  logic               level_i,
    input  logic               wdog_i,
    input  logic               clkmon_i,
    output logic [CAUSE_W-1:0] cause_o
);
    logic               pend_wdog_q;
    logic               pend_clkmon_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] verdict;

    // Classification at the sample point: low pin wins, then watchdog, then clock monitor.
    always_comb begin
        verdict = '0;
        if (!level_i)           verdict[CAUSE_EXT]    = 1'b1;
        else if (pend_wdog_q)   verdict[CAUSE_WDOG]   = 1'b1;
        else if (pend_clkmon_q) verdict[CAUSE_CLKMON] = 1'b1;
        else                    verdict[CAUSE_EXT]    = 1'b1;
    end

    // Pending request capture and cause register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_wdog_q   <= 1'b0;
            pend_clkmon_q <= 1'b0;
            cause_q       <= '0;
        end else if (start_i) begin
            pend_wdog_q   <= wdog_i;
            pend_clkmon_q <= clkmon_i;
            cause_q       <= '0;
        end else begin
            if (collect_i) begin
                pend_wdog_q   <= pend_wdog_q | wdog_i;
                pend_clkmon_q <= pend_clkmon_q | clkmon_i;
            end
            if (clear_i) begin
                pend_wdog_q   <= 1'b0;
                pend_clkmon_q <= 1'b0;
            end
            if (sample_i) cause_q <= verdict;
        end
    end

    assign cause_o = cause_q;

    // R6: the cause word never has more than one bit set.
    p_cause_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o))
        else $error("p_cause_onehot_r6");

    // R4: a low sampled level always yields the external cause.
    p_low_is_external_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !level_i) |=> (cause_o == CAUSE_W'(1 << CAUSE_EXT)))
        else $error("p_low_is_external_r4");
endmodule

// File: rtl/reset_origin_ctrl.sv
// Top: drives the shared reset pin on any reset condition, samples it after release
// and reports whether the reset originated outside or inside the device.
// Assumes: pin_i reflects the wired-AND of this block's drive and any external driver.
module reset_origin_ctrl
    import rsd_pkg::*;
#(
    parameter int DRIVE_CYCLES  = 16,
    parameter int SETTLE_CYCLES = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wdog_req_i,
    input  logic               clkmon_req_i,
    input  logic               pin_i,
    output logic               pin_drive_o,
    output logic               core_rst_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int WAIT_CYCLES = SETTLE_CYCLES + SYNC_STAGES;

    logic       pin_level;
    logic       pin_fall;
    logic       trigger;
    logic       start;
    logic       sample;
    rsd_state_e state;

    assign trigger = wdog_req_i | clkmon_req_i | pin_fall;

    rsd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (pin_level),
        .fall_o  (pin_fall)
    );

    rsd_seq_ctrl #(.DRIVE_CYCLES(DRIVE_CYCLES), .WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trigger_i (trigger),
        .state_o   (state),
        .start_o   (start),
        .sample_o  (sample)
    );

    rsd_cause_reg u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .collect_i ((state == ST_DRIVE) || (state == ST_SETTLE)),
        .clear_i   (state == ST_RELEASE),
        .sample_i  (sample),
        .level_i   (pin_level),
        .wdog_i    (wdog_req_i),
        .clkmon_i  (clkmon_req_i),
        .cause_o   (cause_o)
    );

    assign pin_drive_o = (state == ST_DRIVE);
    assign core_rst_o  = (state != ST_IDLE);

    // R7: the pin is never driven without the internal reset being active.
    p_drive_within_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_o |-> core_rst_o)
        else $error("p_drive_within_reset_r7");

    // R6: the cause word changes only at a sequence start or at the sample point.
    p_cause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cause_o) |-> $past(start || sample))
        else $error("p_cause_hold_r6");
endmodule

// File: tb/tb_reset_origin_ctrl.sv
// Self-checking bench: a behavioural model is compared with the outputs on every clock.
module tb_reset_origin_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdog = 1'b0;
    logic       clkmon = 1'b0;
    logic       ext_low = 1'b0;
    logic       pin;
    logic       drive;
    logic       core_rst;
    logic [2:0] cause;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    int    drive_cnt = 0;
    int    rst_cnt   = 0;
    string tag = "R1";

    // model state
    int       m_phase = 0;
    int       m_cnt = 0;
    bit       m_pw = 0, m_pc = 0;
    bit [2:0] m_cause = 0;
    bit       m_s1 = 1, m_s2 = 1, m_s3 = 1;

    always #5 clk = ~clk;

    assign pin = ~drive & ~ext_low;

    reset_origin_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdog_req_i   (wdog),
        .clkmon_req_i (clkmon),
        .pin_i        (pin),
        .pin_drive_o  (drive),
        .core_rst_o   (core_rst),
        .cause_o      (cause)
    );

    // Behavioural reference: phases with cycle counts taken from the requirements.
    always @(posedge clk) begin
        bit m_pin, fall;
        m_pin = !(m_phase == 1) && !ext_low;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_pw = 0; m_pc = 0; m_cause = 0;
            m_s1 = 1; m_s2 = 1; m_s3 = 1;
        end else begin
            fall = m_s3 && !m_s2;
            case (m_phase)
                0: if (wdog || clkmon || fall) begin
                       m_phase = 1; m_cnt = 0; m_pw = wdog; m_pc = clkmon; m_cause = 0;
                   end
                1: begin
                       m_pw |= wdog; m_pc |= clkmon;
                       if (m_cnt == 15) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
                   end
                2: begin
                       if (m_cnt == 9) begin
                           if (!m_s2)     m_cause = 3'b001;
                           else if (m_pw) m_cause = 3'b010;
                           else if (m_pc) m_cause = 3'b100;
                           else           m_cause = 3'b001;
                           m_phase = 3;
                       end else m_cnt++;
                       m_pw |= wdog; m_pc |= clkmon;
                   end
                default: begin m_phase = 0; m_pw = 0; m_pc = 0; end
            endcase
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = m_pin;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge, plus sequence length counters.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(tag, "pin_drive_o", drive, (m_phase == 1));
            check(tag, "core_rst_o", core_rst, (m_phase != 0));
            check(tag, "cause_o", cause, m_cause);
            check("R6", "cause one-hot", $countones(cause) <= 1, 1);
            if (drive) drive_cnt++;
            if (core_rst) rst_cnt++;
        end
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_seq(string t, bit w, bit c, int ext_len, int exp_cause);
        tag = t; drive_cnt = 0; rst_cnt = 0;
        @(negedge clk);
        wdog = w; clkmon = c; ext_low = (ext_len > 0);
        @(negedge clk);
        wdog = 0; clkmon = 0;
        if (ext_len == 1) ext_low = 0;
        for (int i = 1; i < 60; i++) begin
            @(negedge clk);
            if (i + 1 == ext_len) ext_low = 0;
        end
        check(t, "final cause", cause, exp_cause);
        check("R3", "drive length", drive_cnt, 16);
        check("R7", "core reset length", rst_cnt, 27);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "drive in reset", drive, 0);
        check("R1", "core_rst in reset", core_rst, 0);
        check("R1", "cause in reset", cause, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "cause after reset", cause, 0);
        // R2 R5: watchdog alone
        run_seq("R5", 1, 0, 0, 3'b010);
        // R2 R5: clock monitor alone
        run_seq("R2", 0, 1, 0, 3'b100);
        // R5: both in the same cycle, watchdog wins
        run_seq("R5", 1, 1, 0, 3'b010);
        // R4 R8: external held 40 cycles
        run_seq("R4", 0, 0, 40, 3'b001);
        // R8: external edge and watchdog in the same cycle
        run_seq("R8", 1, 0, 40, 3'b001);
        // R10: short external pulse, pin high at sample
        run_seq("R10", 0, 0, 3, 3'b001);
        // R9: clock monitor starts, watchdog arrives mid-drive
        tag = "R9"; drive_cnt = 0; rst_cnt = 0;
        @(negedge clk); clkmon = 1;
        @(negedge clk); clkmon = 0;
        repeat (5) @(negedge clk);
        wdog = 1;
        @(negedge clk); wdog = 0;
        repeat (50) @(negedge clk);
        check("R9", "late watchdog cause", cause, 3'b010);
        check("R9", "single sequence length", rst_cnt, 27);
        // R6: cause held while idle
        repeat (10) @(negedge clk);
        check("R6", "cause held", cause, 3'b010);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule